// File: doc/BRIEF.md
# Boundary Scan Register with Pin Steering

This block is the chain of boundary cells that sits between a chip's core logic and its digital pads. It observes the input pads, sits in the path of the output pads and their enables, and is worked by an external test access port controller. That controller supplies the capture, shift and update strobes, a select line saying that the boundary register is the current data register, serial test data, and an already latched instruction class. The class is one of: functional, sample/preload, extest, highz or clamp.

Every cell, whether it watches an input, drives an output or gates a group of output enables, has two stages. One is a shift stage on the serial path. The other is a parallel stage that is latched separately. A single set of latched parallel values feeds all the ways the pads can be steered. In functional and sample modes the core drives the pads. In extest mode the latched values drive them. In clamp mode the latched values drive them and are frozen. In highz mode every output enable is switched off. Serial data leaves the chain on the falling clock edge, least significant cell first.

Top module: `bscan_pin_ctl`

## Requirements
- R1: While the test-logic-reset input `rst` is high at a rising edge, the shift and latched stages clear to 0 and `tdo_o` goes to 0 on the next falling edge. While `rst` is high the pads follow the core whatever `mode_i` holds. Once `rst` falls, the pads in extest mode show the cleared latched values (all 0).
- R2: In functional mode (`mode_i` = 0) and in sample mode (`mode_i` = 1), `pad_out_o` equals `core_out_i`. Output `i` belongs to enable group `i / OUT_PER_CTL`, and `pad_oe_o[i]` equals `core_oe_i` of that group.
- R3: A rising edge with `capture_i` and `bsr_sel_i` both high loads the chain. Cells `0..N_IN-1` take `pin_in_i`. Cells `N_IN..N_IN+N_OUT-1` take the values currently on `pad_out_o`. The top `N_CTL` cells take each group's current pad enable.
- R4: A rising edge with `shift_i` and `bsr_sel_i` high moves the chain one cell toward cell 0. `tdi_i` enters cell `CHAIN_LEN-1` and cell 0 is presented on `tdo_o`. After `CHAIN_LEN` shifts, bit `k` of the chain is the `k`-th bit shifted in.
- R5: `tdo_o` changes only on the falling edge of `clk`. Just after a rising edge it still holds the value it had before that edge.
- R6: In sample mode, shifting and updating the chain leave `pad_out_o` and `pad_oe_o` equal to the core values.
- R7: The latched stages load the shift stages only on a rising edge with `update_i` and `bsr_sel_i` both high. Without the select, an update strobe changes nothing.
- R8: In extest mode (`mode_i` = 2), `pad_out_o[i]` equals latched cell `N_IN+i`. `pad_oe_o[i]` equals latched control cell `N_IN+N_OUT+group(i)`. The core values have no effect.
- R9: In clamp mode (`mode_i` = 4) the pads are driven from the latched values and stay constant. Update strobes are ignored, even with the select high.
- R10: In highz mode (`mode_i` = 3) every bit of `pad_oe_o` is 0. Update strobes are ignored.
- R11: The unused mode codes 5, 6 and 7 steer the pads as in functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Test-logic-reset, synchronous, active high |
| mode_i | input | 3 | Latched instruction class: 0 functional, 1 sample, 2 extest, 3 highz, 4 clamp |
| bsr_sel_i | input | 1 | Boundary register is the selected data register |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data into the chain |
| tdo_o | output | 1 | Serial data out, changes on the falling edge |
| pin_in_i | input | N_IN | Values on the input pads |
| core_out_i | input | N_OUT | Output values from the core |
| core_oe_i | input | N_CTL | Group output enables from the core |
| pad_out_o | output | N_OUT | Values driven to the output pads |
| pad_oe_o | output | N_OUT | Per-pad output enables |

## Verification
The bench goes after three things: cell order, the edge on which `tdo_o` moves, and what extest captures. A design that reversed the chain, or put `tdi_i` in at the wrong end, would return captured vectors bit-reversed and drive the wrong pads after a preload. A design that moved `tdo_o` on the rising edge would show the new bit just after capture. A design that captured core values instead of the values on the pads would return the core pattern in extest. The bench also pulses update with the select low, and pulses it under clamp and highz. A design that let these through would change the frozen pads. A design that skipped the pad override during test-logic-reset, or left the latched stages uncleared, would show stale or latched values on the pads around `rst`.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [2:0] {
        BS_FUNC   = 3'd0,
        BS_SAMPLE = 3'd1,
        BS_EXTEST = 3'd2,
        BS_HIGHZ  = 3'd3,
        BS_CLAMP  = 3'd4
    } bs_mode_e;

    typedef struct packed {
        logic cap;
        logic shift;
        logic upd;
    } bs_strobe_t;

    // Unused codes fall back to functional steering (R11).
    function automatic bs_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return BS_SAMPLE;
            3'd2:    return BS_EXTEST;
            3'd3:    return BS_HIGHZ;
            3'd4:    return BS_CLAMP;
            default: return BS_FUNC;
        endcase
    endfunction

    function automatic logic drives_from_latch(input bs_mode_e m);
        return (m == BS_EXTEST) || (m == BS_CLAMP);
    endfunction

    function automatic logic latch_writable(input bs_mode_e m);
        return !((m == BS_CLAMP) || (m == BS_HIGHZ));
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bs_strobe_t stb_i,
    input  logic       cap_d_i,
    input  logic       ser_d_i,
    output logic       ser_q_o,
    output logic       par_q_o
);

    logic ser_q;
    logic par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= 1'b0;
        end else if (stb_i.cap) begin
            ser_q <= cap_d_i;
        end else if (stb_i.shift) begin
            ser_q <= ser_d_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
        end else if (stb_i.upd) begin
            par_q <= ser_q;
        end
    end

    assign ser_q_o = ser_q;
    assign par_q_o = par_q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int LEN = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  bs_strobe_t     stb_i,
    input  logic           tdi_i,
    input  logic [LEN-1:0] cap_vec_i,
    output logic [LEN-1:0] shift_q_o,
    output logic [LEN-1:0] par_q_o
);

    logic [LEN-1:0] ser_in;

    // tdi feeds the far end; each cell takes its upper neighbour.
    assign ser_in = {tdi_i, shift_q_o[LEN-1:1]};

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        bscan_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .stb_i   (stb_i),
            .cap_d_i (cap_vec_i[k]),
            .ser_d_i (ser_in[k]),
            .ser_q_o (shift_q_o[k]),
            .par_q_o (par_q_o[k])
        );
    end

    // R4: one shift moves every cell one place toward cell 0
    p_shift_move_r4: assert property (@(posedge clk) disable iff (rst)
        (stb_i.shift && !stb_i.cap) |=>
            (shift_q_o[LEN-2:0] == $past(shift_q_o[LEN-1:1])) &&
            (shift_q_o[LEN-1] == $past(tdi_i)));

    // R7: latched stage holds without an update strobe
    p_upd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !stb_i.upd |=> $stable(par_q_o));

    // R3: capture loads the parallel capture vector
    p_capture_load_r3: assert property (@(posedge clk) disable iff (rst)
        stb_i.cap |=> shift_q_o == $past(cap_vec_i));

endmodule

// File: rtl/bscan_steer.sv
module bscan_steer
    import bscan_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int N_CTL       = 2,
    parameter int OUT_PER_CTL = 2
) (
    input  bs_mode_e           mode_i,
    input  logic [N_OUT-1:0]   core_out_i,
    input  logic [N_CTL-1:0]   core_oe_i,
    input  logic [N_OUT-1:0]   lat_out_i,
    input  logic [N_CTL-1:0]   lat_ctl_i,
    output logic [N_OUT-1:0]   pad_out_o,
    output logic [N_OUT-1:0]   pad_oe_o,
    output logic [N_CTL-1:0]   grp_oe_o
);

    logic use_latch;

    assign use_latch = drives_from_latch(mode_i);

    always_comb begin
        if (mode_i == BS_HIGHZ) begin
            grp_oe_o = '0;
        end else if (use_latch) begin
            grp_oe_o = lat_ctl_i;
        end else begin
            grp_oe_o = core_oe_i;
        end
    end

    assign pad_out_o = use_latch ? lat_out_i : core_out_i;

    for (genvar i = 0; i < N_OUT; i++) begin : g_oe
        assign pad_oe_o[i] = grp_oe_o[i / OUT_PER_CTL];
    end

endmodule

// File: rtl/bscan_tdo.sv
module bscan_tdo (
    input  logic clk,
    input  logic rst,
    input  logic sr0_i,
    output logic tdo_o
);

    logic tdo_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            tdo_q <= 1'b0;
        end else begin
            tdo_q <= sr0_i;
        end
    end

    assign tdo_o = tdo_q;

    // R5: at each rising edge tdo already shows cell 0 as set by the last edge
    p_tdo_negedge_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tdo_q == sr0_i);

endmodule

// File: rtl/bscan_pin_ctl.sv
module bscan_pin_ctl
    import bscan_pkg::*;
#(
    parameter int N_IN        = 4,
    parameter int N_CTL       = 2,
    parameter int OUT_PER_CTL = 2,
    localparam int N_OUT      = N_CTL * OUT_PER_CTL,
    localparam int CHAIN_LEN  = N_IN + N_OUT + N_CTL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic              bsr_sel_i,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic [N_IN-1:0]   pin_in_i,
    input  logic [N_OUT-1:0]  core_out_i,
    input  logic [N_CTL-1:0]  core_oe_i,
    output logic [N_OUT-1:0]  pad_out_o,
    output logic [N_OUT-1:0]  pad_oe_o
);

    localparam int OUT_LO = N_IN;
    localparam int CTL_LO = N_IN + N_OUT;

    bs_mode_e              mode_e;
    bs_strobe_t            stb;
    logic [CHAIN_LEN-1:0]  cap_vec;
    logic [CHAIN_LEN-1:0]  shift_q;
    logic [CHAIN_LEN-1:0]  par_q;
    logic [N_CTL-1:0]      grp_oe;

    // Test-logic-reset forces functional steering (R1).
    assign mode_e = rst ? BS_FUNC : decode_mode(mode_i);

    always_comb begin
        stb.cap   = capture_i & bsr_sel_i;
        stb.shift = shift_i & bsr_sel_i;
        stb.upd   = update_i & bsr_sel_i & latch_writable(mode_e);
    end

    // Capture sees the pad side: input pads, driven values, group enables.
    assign cap_vec = {grp_oe, pad_out_o, pin_in_i};

    bscan_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .stb_i     (stb),
        .tdi_i     (tdi_i),
        .cap_vec_i (cap_vec),
        .shift_q_o (shift_q),
        .par_q_o   (par_q)
    );

    bscan_steer #(
        .N_OUT       (N_OUT),
        .N_CTL       (N_CTL),
        .OUT_PER_CTL (OUT_PER_CTL)
    ) u_steer (
        .mode_i     (mode_e),
        .core_out_i (core_out_i),
        .core_oe_i  (core_oe_i),
        .lat_out_i  (par_q[OUT_LO +: N_OUT]),
        .lat_ctl_i  (par_q[CTL_LO +: N_CTL]),
        .pad_out_o  (pad_out_o),
        .pad_oe_o   (pad_oe_o),
        .grp_oe_o   (grp_oe)
    );

    bscan_tdo u_tdo (
        .clk   (clk),
        .rst   (rst),
        .sr0_i (shift_q[0]),
        .tdo_o (tdo_o)
    );

    // R1: during test-logic-reset the pads follow the core
    p_reset_func_r1: assert property (@(posedge clk)
        rst |-> pad_out_o == core_out_i);

    // R10: highz switches off every output enable
    p_highz_off_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd3) |-> pad_oe_o == '0);

    // R9: clamp keeps the pads frozen from one cycle to the next
    p_clamp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd4 && $past(mode_i) == 3'd4 && !$past(rst)) |->
            ($stable(pad_out_o) && $stable(pad_oe_o)));

    // R8: extest ignores the core outputs
    p_extest_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd2 && $past(mode_i) == 3'd2 && !$past(rst) && !$past(stb.upd))
            |-> $stable(pad_out_o));

endmodule

// File: tb/sim_bscan_pin_ctl.sv
module sim_bscan_pin_ctl;

    localparam int NI  = 4;
    localparam int NC  = 2;
    localparam int OPC = 2;
    localparam int NO  = NC * OPC;
    localparam int L   = NI + NO + NC;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    mode;
    logic          sel, cap, sh, upd, tdi;
    logic          tdo;
    logic [NI-1:0] pin_in;
    logic [NO-1:0] core_out;
    logic [NC-1:0] core_oe;
    logic [NO-1:0] pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [L-1:0] lat   = '0;
    logic         prev0 = 1'b0;

    always #5 clk = ~clk;

    bscan_pin_ctl #(.N_IN(NI), .N_CTL(NC), .OUT_PER_CTL(OPC)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .bsr_sel_i(sel),
        .capture_i(cap), .shift_i(sh), .update_i(upd), .tdi_i(tdi),
        .tdo_o(tdo), .pin_in_i(pin_in), .core_out_i(core_out),
        .core_oe_i(core_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [NO-1:0] xoe(input logic [NC-1:0] c);
        logic [NO-1:0] r;
        for (int i = 0; i < NO; i++) r[i] = c[i / OPC];
        return r;
    endfunction

    function automatic logic [L-1:0] exp_cap();
        if (mode == 3'd2 || mode == 3'd4)
            return {lat[NI+NO +: NC], lat[NI +: NO], pin_in};
        return {core_oe, core_out, pin_in};
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic scan(input logic [L-1:0] din, input logic s, input logic u,
                        output logic [L-1:0] dout);
        sel = s; cap = 1'b1;
        step();
        cap = 1'b0;
        if (s) chk("R5 tdo held across rising edge", {31'b0, tdo}, {31'b0, prev0});
        for (int k = 0; k < L; k++) begin
            sh = 1'b1; tdi = din[k];
            @(negedge clk); #1;
            dout[k] = tdo;
            @(posedge clk); #1;
        end
        sh = 1'b0; upd = u;
        step();
        upd = 1'b0; sel = 1'b0;
        if (s) prev0 = din[0];
        if (s && u && mode != 3'd3 && mode != 3'd4) lat = din;
    endtask

    task automatic chk_latched(input string tag);
        chk(tag, {28'b0, pad_out}, {28'b0, lat[NI +: NO]});
        chk(tag, {28'b0, pad_oe}, {28'b0, xoe(lat[NI+NO +: NC])});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] dout, expv;
        rst = 1'b1; mode = 3'd2; sel = 0; cap = 0; sh = 0; upd = 0; tdi = 0;
        pin_in = 4'h9; core_out = 4'h6; core_oe = 2'b10;
        step(); step();
        // R1: reset steering and cleared serial output
        chk("R1 pads follow core in reset", {28'b0, pad_out}, 32'h6);
        chk("R1 enables follow core in reset", {28'b0, pad_oe}, {28'b0, xoe(2'b10)});
        @(negedge clk); #1;
        chk("R1 tdo cleared", {31'b0, tdo}, 32'h0);
        step();
        rst = 1'b0;
        #1;
        chk_latched("R1 cleared latch after reset in extest");
        mode = 3'd0;

        // R2: functional sweep
        for (int v = 0; v < 64; v++) begin
            core_out = v[3:0]; core_oe = v[5:4];
            #1;
            chk("R2 functional pad_out", {28'b0, pad_out}, {28'b0, v[3:0]});
            chk("R2 functional pad_oe", {28'b0, pad_oe}, {28'b0, xoe(v[5:4])});
        end

        // R11: unused codes steer like functional
        for (int m = 5; m < 8; m++) begin
            mode = m[2:0]; core_out = 4'(m * 3); core_oe = 2'(m);
            #1;
            chk("R11 unused code pad_out", {28'b0, pad_out}, {28'b0, 4'(m * 3)});
            chk("R11 unused code pad_oe", {28'b0, pad_oe}, {28'b0, xoe(2'(m))});
        end

        // Sample/preload: capture, order, no effect on pins
        mode = 3'd1;
        for (int p = 0; p < 16; p++) begin
            pin_in = p[3:0]; core_out = ~p[3:0]; core_oe = p[1:0] ^ 2'b01;
            #1;
            expv = exp_cap();
            scan(10'((p * 37 + 11) & 10'h3ff), 1'b1, 1'b1, dout);
            chk("R3/R4 sample capture order", {22'b0, dout}, {22'b0, expv});
            chk("R6 sample pad_out unchanged", {28'b0, pad_out}, {28'b0, ~p[3:0]});
            chk("R6 sample pad_oe unchanged", {28'b0, pad_oe}, {28'b0, xoe(p[1:0] ^ 2'b01)});
        end

        // Extest: latched drive, capture from pads
        mode = 3'd2;
        #1;
        chk_latched("R8 preload shows on entering extest");
        for (int p = 0; p < 16; p++) begin
            pin_in = 4'(p + 3); core_out = 4'(p * 5); core_oe = p[2:1];
            #1;
            expv = exp_cap();
            scan(10'((p * 91 + 3) & 10'h3ff), 1'b1, 1'b1, dout);
            chk("R3/R4 extest capture from pads", {22'b0, dout}, {22'b0, expv});
            chk_latched("R8 extest drive");
            core_out = ~core_out; core_oe = ~core_oe;
            #1;
            chk_latched("R8 core ignored in extest");
        end

        // R7: update without select
        scan(10'h2a5, 1'b0, 1'b1, dout);
        chk_latched("R7 unselected update ignored");

        // Clamp: frozen latched values
        mode = 3'd4;
        #1;
        chk_latched("R9 clamp drives latched values");
        for (int p = 0; p < 6; p++) begin
            core_out = 4'(p * 7); core_oe = 2'(p);
            scan(10'((p * 53 + 17) & 10'h3ff), 1'b1, 1'b1, dout);
            chk_latched("R9 clamp holds through update");
        end

        // Highz: all enables off, updates ignored
        mode = 3'd3;
        for (int c = 0; c < 4; c++) begin
            core_oe = c[1:0]; core_out = 4'(c + 9);
            #1;
            chk("R10 highz enables off", {28'b0, pad_oe}, 32'h0);
        end
        scan(10'h155, 1'b1, 1'b1, dout);
        mode = 3'd2;
        #1;
        chk_latched("R10 highz update ignored");

        // R1: test-logic-reset clears latched stage
        lat = 10'h3ff;
        mode = 3'd1;
        scan(10'h3ff, 1'b1, 1'b1, dout);
        mode = 3'd2;
        #1;
        chk_latched("R1 latch loaded before reset");
        core_out = 4'h5; core_oe = 2'b01;
        rst = 1'b1;
        step();
        chk("R1 reset overrides extest", {28'b0, pad_out}, 32'h5);
        rst = 1'b0;
        lat = '0; prev0 = 1'b0;
        #1;
        chk_latched("R1 latch cleared by reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule